// File: doc/BRIEF.md
# Quarter-Wave Sine Generator With Angle-Sum Correction

This block turns a phase word into a signed sine amplitude. The caller supplies the phase within one quarter of a cycle plus two quadrant bits. The `slope_i` bit says that the phase is on the falling half of a half-cycle. The `sign_i` bit says that the phase is in the negative half of the cycle. Only a quarter wave is stored. When `slope_i` is set, the in-quadrant phase is replaced by its ones' complement. The polarity is applied on the last stage.

The folded phase is split into a coarse part (its upper bits) and a fine part (its lower bits). The sine is formed from the angle-sum identity. The cosine of the fine angle is taken as exactly one. The amplitude is a coarse table value at the coarse angle plus a narrow correction term. The correction approximates cos(coarse)·sin(fine) and comes from a second table. That table is addressed by the top bits of the coarse part and the top bits of the fine part. Both tables are computed at elaboration by integer constant functions.

Every stored angle sits half a phase step above its integer phase. This makes the ones' complement fold an exact mirror. The path is three registers deep, and a valid flag travels alongside the data.

Top module: `qsin_gen`

## Requirements
- R1: `valid_o` equals the `valid_i` value accepted three rising clock edges earlier, and `sample_o` carries the result of that same input.
- R2: For the full phase f = {sign_i, slope_i, phase_i} (sign_i is the top bit, phase_i the low 12 bits), the output is within 8 LSB of round(32767·sin(2π·(f + 0.5)/16384)) for every one of the 16384 phases.
- R3: An input with slope_i = 1 and in-quadrant phase p gives exactly the same output as slope_i = 0 with phase ~p (bitwise inverse), for the same sign_i.
- R4: An input with sign_i = 1 gives exactly the arithmetic negation of the output for the same phase_i and slope_i with sign_i = 0.
- R5: The quarter-wave sum saturates at +32767 instead of wrapping, so sample_o stays within −32767..+32767 and never shows −32768, including at the quadrant peaks.
- R6: While rst_n is low, and from the moment it falls, valid_o is 0 and sample_o is 0; inputs accepted before a reset never emerge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input phase is valid this cycle |
| sign_i | input | 1 | Negative half-cycle: negate the result |
| slope_i | input | 1 | Falling part of the half-cycle: mirror the phase |
| phase_i | input | PHASE_W (12) | Phase within the quadrant |
| valid_o | output | 1 | Output sample valid |
| sample_o | output | OUT_W (16) | Two's-complement amplitude |

## Verification
The bench sweeps all 16384 phases back to back against an ideal sine model. This catches a wrong half-step offset, a swapped quadrant bit or a badly indexed correction table, each of which puts whole regions outside the tolerance. The mirror and negation pairs are compared for exact equality. A design that mirrored with a two's complement would be off by one phase step there, and a design that negated before saturating or inverted the sign would break the pair. The quadrant peaks are driven on purpose, because there the coarse value plus the correction exceeds full scale: a design without saturation would wrap to a large negative code. A reset in the middle of a stream shows whether stale entries leak out after reset is released.

// File: rtl/qsin_pkg.sv
package qsin_pkg;

   // pi/2 in fixed point, 30 fractional bits
   localparam longint HALF_PI_FX = 64'sd1686629713;
   localparam int     FX_SH      = 30;

   // sine by Taylor series, argument and result with 30 fractional bits
   function automatic longint fx_sin(input longint x);
      longint term;
      longint acc;
      term = x;
      acc  = x;
      for (int k = 1; k <= 8; k++) begin
         term = (term * x) >>> FX_SH;
         term = (term * x) >>> FX_SH;
         term = -term / longint'((2 * k) * (2 * k + 1));
         acc  = acc + term;
      end
      return acc;
   endfunction

   function automatic longint fx_cos(input longint x);
      return fx_sin(HALF_PI_FX - x);
   endfunction

   // angle of phase step n plus half a step, quarter wave spans 2**phase_w steps
   function automatic longint step_angle(input longint n, input int phase_w);
      return ((2 * n + 1) * HALF_PI_FX) >>> (phase_w + 1);
   endfunction

   function automatic int coarse_val(input int idx, input int phase_w,
                                     input int fine_w, input int amp);
      longint s;
      longint r;
      s = fx_sin(step_angle(longint'(idx) << fine_w, phase_w));
      r = (s * amp + (longint'(1) <<< (FX_SH - 1))) >>> FX_SH;
      if (r > amp) r = amp;
      if (r < 0)   r = 0;
      return int'(r);
   endfunction

   function automatic int corr_val(input int a_hi, input int b_hi,
                                   input int phase_w, input int coarse_w,
                                   input int fine_w, input int ca_w,
                                   input int cb_w, input int amp);
      longint a_mid;
      longint b_val;
      longint ang_b;
      longint prod;
      longint r;
      a_mid = (longint'(a_hi) << (coarse_w - ca_w)) + (longint'(1) << (coarse_w - ca_w - 1));
      b_val = longint'(b_hi) << (fine_w - cb_w);
      ang_b = (b_val * HALF_PI_FX) >>> phase_w;
      prod  = (fx_cos(step_angle(a_mid << fine_w, phase_w)) * fx_sin(ang_b)) >>> FX_SH;
      r     = (prod * amp + (longint'(1) <<< (FX_SH - 1))) >>> FX_SH;
      if (r < 0) r = 0;
      return int'(r);
   endfunction

endpackage

// File: rtl/qsin_fold.sv
module qsin_fold #(
   parameter int PHASE_W  = 12,
   parameter int COARSE_W = 8,
   parameter int CA_W     = 5,
   parameter int CB_W     = 4
) (
   input  logic [PHASE_W-1:0]     phase_i,
   input  logic                   slope_i,
   output logic [COARSE_W-1:0]    coarse_addr_o,
   output logic [CA_W+CB_W-1:0]   corr_addr_o
);
   localparam int FINE_W = PHASE_W - COARSE_W;

   logic [PHASE_W-1:0] folded;
   logic [FINE_W-1:0]  fine;
   logic [CB_W-1:0]    fine_hi;

   // mirror within the quadrant by ones' complement
   always_comb folded = slope_i ? ~phase_i : phase_i;

   assign coarse_addr_o = folded[PHASE_W-1 -: COARSE_W];
   assign fine          = folded[FINE_W-1:0];

   generate
      if (CB_W == FINE_W) begin : g_full_fine
         assign fine_hi = fine;
      end else begin : g_trunc_fine
         assign fine_hi = fine[FINE_W-1 -: CB_W];
      end
   endgenerate

   assign corr_addr_o = {coarse_addr_o[COARSE_W-1 -: CA_W], fine_hi};

endmodule

// File: rtl/qsin_tables.sv
module qsin_tables #(
   parameter int PHASE_W  = 12,
   parameter int COARSE_W = 8,
   parameter int CA_W     = 5,
   parameter int CB_W     = 4,
   parameter int OUT_W    = 16,
   parameter int CORR_W   = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [COARSE_W-1:0]    coarse_addr_i,
   input  logic [CA_W+CB_W-1:0]   corr_addr_i,
   output logic [OUT_W-2:0]       coarse_o,
   output logic [CORR_W-1:0]      corr_o
);
   localparam int FINE_W   = PHASE_W - COARSE_W;
   localparam int MAG_W    = OUT_W - 1;
   localparam int AMP      = (1 << MAG_W) - 1;
   localparam int COARSE_N = 1 << COARSE_W;
   localparam int CORR_N   = 1 << (CA_W + CB_W);

   logic [MAG_W-1:0]  coarse_rom [COARSE_N];
   logic [CORR_W-1:0] corr_rom   [CORR_N];

   for (genvar i = 0; i < COARSE_N; i++) begin : g_coarse
      localparam int VAL = qsin_pkg::coarse_val(i, PHASE_W, FINE_W, AMP);
      assign coarse_rom[i] = MAG_W'(VAL);
   end

   for (genvar j = 0; j < CORR_N; j++) begin : g_corr
      localparam int VAL = qsin_pkg::corr_val(j >> CB_W, j & ((1 << CB_W) - 1),
                                              PHASE_W, COARSE_W, FINE_W,
                                              CA_W, CB_W, AMP);
      assign corr_rom[j] = CORR_W'(VAL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coarse_o <= '0;
         corr_o   <= '0;
      end else begin
         coarse_o <= coarse_rom[coarse_addr_i];
         corr_o   <= corr_rom[corr_addr_i];
      end
   end

endmodule

// File: rtl/qsin_combine.sv
module qsin_combine #(
   parameter int MAG_W  = 15,
   parameter int CORR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MAG_W-1:0]  coarse_i,
   input  logic [CORR_W-1:0] corr_i,
   output logic [MAG_W-1:0]  sum_o
);
   logic [MAG_W:0]   raw;
   logic [MAG_W-1:0] sat;

   always_comb begin
      raw = {1'b0, coarse_i} + {{(MAG_W + 1 - CORR_W){1'b0}}, corr_i};
      sat = raw[MAG_W] ? {MAG_W{1'b1}} : raw[MAG_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sum_o <= '0;
      else        sum_o <= sat;
   end

   // R5: saturating sum never falls below the coarse term it was built from
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (sum_o >= $past(coarse_i)));

endmodule

// File: rtl/qsin_gen.sv
module qsin_gen #(
   parameter int PHASE_W  = 12,
   parameter int COARSE_W = 8,
   parameter int CA_W     = 5,
   parameter int CB_W     = 4,
   parameter int OUT_W    = 16,
   parameter int CORR_W   = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    valid_i,
   input  logic                    sign_i,
   input  logic                    slope_i,
   input  logic [PHASE_W-1:0]      phase_i,
   output logic                    valid_o,
   output logic signed [OUT_W-1:0] sample_o
);
   localparam int FINE_W    = PHASE_W - COARSE_W;
   localparam int MAG_W     = OUT_W - 1;
   localparam int AMP       = (1 << MAG_W) - 1;
   localparam int LATENCY   = 3;
   localparam int CORR_PEAK = qsin_pkg::corr_val(0, (1 << CB_W) - 1, PHASE_W, COARSE_W,
                                                 FINE_W, CA_W, CB_W, AMP);

   // elaboration-time parameter checks
   if (COARSE_W < 2 || COARSE_W >= PHASE_W) begin : g_bad_coarse
      $error("qsin_gen: COARSE_W must be in 2..PHASE_W-1");
   end
   if (CA_W < 1 || CA_W >= COARSE_W) begin : g_bad_ca
      $error("qsin_gen: CA_W must be in 1..COARSE_W-1");
   end
   if (CB_W < 1 || CB_W > FINE_W) begin : g_bad_cb
      $error("qsin_gen: CB_W must be in 1..FINE_W");
   end
   if (PHASE_W > 20 || OUT_W > 24 || OUT_W < 4) begin : g_bad_range
      $error("qsin_gen: PHASE_W or OUT_W outside the fixed-point range");
   end
   if (CORR_W > MAG_W || CORR_PEAK >= (1 << CORR_W)) begin : g_bad_corr
      $error("qsin_gen: CORR_W cannot hold the correction peak");
   end

   logic [COARSE_W-1:0]    coarse_addr;
   logic [CA_W+CB_W-1:0]   corr_addr;
   logic [MAG_W-1:0]       coarse_q;
   logic [CORR_W-1:0]      corr_q;
   logic [MAG_W-1:0]       sum_q;
   logic [LATENCY-1:0]     vld_pipe;
   logic [1:0]             sign_pipe;
   logic signed [OUT_W-1:0] mag_s;

   qsin_fold #(
      .PHASE_W (PHASE_W),
      .COARSE_W(COARSE_W),
      .CA_W    (CA_W),
      .CB_W    (CB_W)
   ) u_fold (
      .phase_i      (phase_i),
      .slope_i      (slope_i),
      .coarse_addr_o(coarse_addr),
      .corr_addr_o  (corr_addr)
   );

   qsin_tables #(
      .PHASE_W (PHASE_W),
      .COARSE_W(COARSE_W),
      .CA_W    (CA_W),
      .CB_W    (CB_W),
      .OUT_W   (OUT_W),
      .CORR_W  (CORR_W)
   ) u_tables (
      .clk          (clk),
      .rst_n        (rst_n),
      .coarse_addr_i(coarse_addr),
      .corr_addr_i  (corr_addr),
      .coarse_o     (coarse_q),
      .corr_o       (corr_q)
   );

   qsin_combine #(
      .MAG_W (MAG_W),
      .CORR_W(CORR_W)
   ) u_combine (
      .clk     (clk),
      .rst_n   (rst_n),
      .coarse_i(coarse_q),
      .corr_i  (corr_q),
      .sum_o   (sum_q)
   );

   assign mag_s = signed'({1'b0, sum_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_pipe  <= '0;
         sign_pipe <= '0;
         sample_o  <= '0;
      end else begin
         vld_pipe  <= {vld_pipe[LATENCY-2:0], valid_i};
         sign_pipe <= {sign_pipe[0], sign_i};
         sample_o  <= sign_pipe[1] ? -mag_s : mag_s;
      end
   end

   assign valid_o = vld_pipe[LATENCY-1];

   // cycles since reset, saturating, so history checks never look before reset
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R1: valid follows the input three edges later
   a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3) |-> (valid_o == $past(valid_i, 3)));

   // R4: polarity of a nonzero sample matches the sign bit accepted three edges before
   a_r4_sign_polarity: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && valid_o && sample_o != '0) |-> (sample_o[OUT_W-1] == $past(sign_i, 3)));

   // R5: the most negative code never appears
   a_r5_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (sample_o != {1'b1, {(OUT_W-1){1'b0}}}));

   // R6: nothing valid in the first cycle out of reset
   a_r6_reset_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd0) |-> !valid_o);

endmodule

// File: tb/qsin_gen_bench.sv
module qsin_gen_bench;
   localparam int  CLK_PERIOD = 10;
   localparam int  TOL        = 8;
   localparam real TWO_PI     = 6.283185307179586;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               valid_i = 1'b0;
   logic               sign_i = 1'b0;
   logic               slope_i = 1'b0;
   logic [11:0]        phase_i = '0;
   logic               valid_o;
   logic signed [15:0] sample_o;

   int n_checks = 0;
   int n_fail   = 0;

   // {sign, slope, phase[11:0]}
   localparam logic [13:0] VEC [16] = '{
      14'h0000, 14'h0FFF, 14'h1000, 14'h1FFF,
      14'h2000, 14'h2FFF, 14'h3000, 14'h3FFF,
      14'h0800, 14'h0123, 14'h1ABC, 14'h2555,
      14'h3AAA, 14'h0001, 14'h2001, 14'h17FF
   };

   qsin_gen u_qsin_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (valid_i),
      .sign_i  (sign_i),
      .slope_i (slope_i),
      .phase_i (phase_i),
      .valid_o (valid_o),
      .sample_o(sample_o)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic int ideal(input logic [13:0] v);
      real ang;
      ang = TWO_PI * (real'(int'(v)) + 0.5) / 16384.0;
      return int'(32767.0 * $sin(ang));
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_acc(input logic [13:0] v, input string req);
      int act;
      int exp;
      act = int'(sample_o);
      exp = ideal(v);
      chk(act >= exp - TOL && act <= exp + TOL, req, act, exp);
   endtask

   task automatic finish_up;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   endtask

   // back-to-back stream, from the table or as a full-cycle sweep
   task automatic stream(input bit sweep, input int count);
      bit          dv [3];
      logic [13:0] dvec [3];
      logic [13:0] v;
      for (int i = 0; i < 3; i++) begin
         dv[i]   = 1'b0;
         dvec[i] = '0;
      end
      for (int k = 0; k < count + 3; k++) begin
         @(negedge clk);
         chk(valid_o == dv[2], "R1", int'(valid_o), int'(dv[2]));
         if (dv[2]) chk_acc(dvec[2], "R2");
         dv[2] = dv[1]; dvec[2] = dvec[1];
         dv[1] = dv[0]; dvec[1] = dvec[0];
         if (k < count) begin
            v = sweep ? 14'(k) : VEC[k];
            {sign_i, slope_i, phase_i} = v;
            valid_i = 1'b1;
            dv[0]   = 1'b1;
            dvec[0] = v;
         end else begin
            valid_i = 1'b0;
            dv[0]   = 1'b0;
         end
      end
   endtask

   task automatic single(input logic [13:0] v, output int res);
      @(negedge clk);
      {sign_i, slope_i, phase_i} = v;
      valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      res = int'(sample_o);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_up();
   end

   initial begin
      int r_a;
      int r_b;
      int ph [6] = '{0, 1, 37, 2048, 3000, 4095};

      // R6: reset state
      @(negedge clk);
      @(negedge clk);
      chk(valid_o == 1'b0, "R6", int'(valid_o), 0);
      chk(sample_o == 16'sd0, "R6", int'(sample_o), 0);
      rst_n = 1'b1;

      // R1, R2: table walk
      stream(1'b0, 16);

      // R2, R1: every phase of the cycle
      stream(1'b1, 16384);

      // R3: ones' complement mirror, both signs
      foreach (ph[i]) begin
         single({1'b0, 1'b1, 12'(ph[i])}, r_a);
         single({1'b0, 1'b0, ~12'(ph[i])}, r_b);
         chk(r_a == r_b, "R3", r_a, r_b);
         single({1'b1, 1'b1, 12'(ph[i])}, r_a);
         single({1'b1, 1'b0, ~12'(ph[i])}, r_b);
         chk(r_a == r_b, "R3", r_a, r_b);
      end

      // R4: sign bit negates exactly
      foreach (ph[i]) begin
         for (int sl = 0; sl < 2; sl++) begin
            single({1'b1, 1'(sl), 12'(ph[i])}, r_a);
            single({1'b0, 1'(sl), 12'(ph[i])}, r_b);
            chk(r_a == -r_b, "R4", r_a, -r_b);
         end
      end

      // R5: quadrant peaks stay in range and near full scale
      single(14'h0FFF, r_a);
      chk(r_a <= 32767 && r_a >= 32767 - TOL, "R5", r_a, 32767);
      single(14'h1000, r_a);
      chk(r_a <= 32767 && r_a >= 32767 - TOL, "R5", r_a, 32767);
      single(14'h2FFF, r_a);
      chk(r_a >= -32767 && r_a <= -32767 + TOL, "R5", r_a, -32767);
      single(14'h3000, r_a);
      chk(r_a >= -32767 && r_a <= -32767 + TOL, "R5", r_a, -32767);

      // R6: reset in the middle of a stream flushes the pipeline
      @(negedge clk);
      {sign_i, slope_i, phase_i} = 14'h0800;
      valid_i = 1'b1;
      @(negedge clk);
      @(negedge clk);
      valid_i = 1'b0;
      rst_n   = 1'b0;
      #1;
      chk(valid_o == 1'b0, "R6", int'(valid_o), 0);
      chk(sample_o == 16'sd0, "R6", int'(sample_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk(valid_o == 1'b0, "R6", int'(valid_o), 0);
      end

      finish_up();
   end

endmodule